// File: doc/BRIEF.md
# Burst SRAM Write Strobe and Output Drive Controller

This block sits between the control pins of a 32-bit synchronous burst SRAM and its storage array. On every active clock edge it turns the write controls into a registered per-byte write mask. The write controls are a global write, a byte-write gate, one enable per byte lane and the processor address strobe. In the same edge it registers the incoming write data and the data read from the array. The data pins are modelled as a data word plus one drive-enable output, with no tri-state buffer. The drive enable combines the output-enable pin, the registered chip selection and whether a write is in flight.

Two banks of such SRAMs can share one data bus and take turns through chip enable. For that case, the `DUAL_BANK` parameter adds one cycle of delay before the drivers turn on after a bank is reselected. This keeps the outgoing bank and the incoming bank from driving the bus together. With `DUAL_BANK = 0` the selects are assumed to be tied active, and the drivers follow selection with no extra cycle.

The sleep input models internal clock gating. While it is high, every register in the block holds its value.

Top module: `bsram_wr_oe_ctl`

## Requirements
- R1: While `rst_n` is low, `wr_mask`, `wdata_q` and `rdata_q` are zero and `drive_en` is 0, whatever the other inputs are.
- R2: At an active edge with `ads_n` high and `gw_n` low, `wr_mask` becomes all ones after that edge, whatever `bwg_n` and `be_n` are.
- R3: At an active edge with `ads_n` high, `gw_n` high and `bwg_n` low, `wr_mask[i]` becomes the inverse of `be_n[i]`. Bit 0 covers data bits 7:0, bit 1 covers bits 15:8, and so on up to bit 3 covering bits 31:24.
- R4: At an active edge with `ads_n`, `gw_n` and `bwg_n` all high, `wr_mask` becomes zero, whatever `be_n` is.
- R5: At an active edge with `ads_n` low, `wr_mask` becomes zero, even if `gw_n` or the byte path requests a write.
- R6: At every active edge, `wdata_q` takes `wdata_in` and `rdata_q` takes `mem_rdata`.
- R7: `drive_en` is 0 in every cycle in which `wr_mask` is nonzero.
- R8: `drive_en` is 0 whenever `oe_n` is high. The output follows `oe_n` in the same cycle, with no clock edge in between.
- R9: With `DUAL_BANK = 1`, after an edge at which the chip becomes selected (`ce_n` low, `cs_hi` high, `cs_lo_n` low) following a deselected edge, `drive_en` stays 0 for one cycle. From the next edge onward it may be 1.
- R10: With `DUAL_BANK = 0`, `drive_en` is 1 in the first cycle after a selecting edge, provided `oe_n` is low and `wr_mask` is zero.
- R11: An edge with `sleep` high is not an active edge: `wr_mask`, `wdata_q`, `rdata_q` and the registered selection all keep their values.
- R12: `drive_en` is 1 only if the chip was selected at the most recent active edge. `drive_en` = (`oe_n` low) AND (`wr_mask` zero) AND (selected) AND (the dual-bank qualification, where that mode is on).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | High gates the internal clock; registers hold |
| gw_n | input | 1 | Global write, active low; writes all bytes |
| bwg_n | input | 1 | Byte-write gate, active low; passes `be_n` through |
| be_n | input | 4 | Per-byte write enables, active low; bit i covers byte lane i |
| ads_n | input | 1 | Processor address strobe, active low; vetoes every write |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; acts without a clock edge |
| wdata_in | input | 32 | Write data from the data pins |
| mem_rdata | input | 32 | Read data from the storage array |
| wr_mask | output | 4 | Registered per-byte write strobes, active high |
| wdata_q | output | 32 | Registered write data |
| rdata_q | output | 32 | Registered read data, to be driven onto the pins |
| drive_en | output | 1 | High when the data pins should be driven |

## Verification
The assertions assume that `sleep` and every control input are steady around the rising edge. They also assume that `oe_n` changes only between edges, so each registered term reflects exactly one sampled set of inputs. The stimulus drives every input on the falling edge and checks on the next falling edge, before new values are applied. Phases with single-byte, all-byte and vetoed writes are mixed with phases that toggle selection and output enable. A long pseudo-random stretch then combines all of them, including sleep cycles, so that deselect-then-reselect sequences meet both bank modes.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

   // Which kind of write one sampled edge requests.
   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,
      WR_BYTES  = 2'd1,
      WR_GLOBAL = 2'd2
   } wr_kind_e;

   // The strobe veto outranks the global write, which outranks the gated byte path.
   function automatic wr_kind_e classify_write(input logic gw_n,
                                               input logic bwg_n,
                                               input logic ads_n);
      wr_kind_e k;
      if (!ads_n)      k = WR_NONE;
      else if (!gw_n)  k = WR_GLOBAL;
      else if (!bwg_n) k = WR_BYTES;
      else             k = WR_NONE;
      return k;
   endfunction

endpackage

// File: rtl/bsw_write_decode.sv
module bsw_write_decode
   import bsw_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 gw_n,
   input  logic                 bwg_n,
   input  logic [NUM_LANES-1:0] be_n,
   input  logic                 ads_n,
   output logic [NUM_LANES-1:0] wr_mask
);

   localparam logic [NUM_LANES-1:0] ALL_LANES = {NUM_LANES{1'b1}};

   wr_kind_e               kind;
   logic [NUM_LANES-1:0]   lane_next;

   always_comb kind = classify_write(gw_n, bwg_n, ads_n);

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      always_comb lane_next[i] = (kind == WR_GLOBAL) || ((kind == WR_BYTES) && !be_n[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   wr_mask[i] <= 1'b0;
         else if (run) wr_mask[i] <= lane_next[i];
      end
   end

   // R2: a global write reaches every lane.
   p_global_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ads_n && !gw_n) |=> (wr_mask == ALL_LANES));

   // R5: the strobe vetoes every write.
   p_strobe_veto_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ads_n) |=> (wr_mask == '0));

   // R4: a closed gate blocks the byte enables.
   p_gate_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ads_n && gw_n && bwg_n) |=> (wr_mask == '0));

   // R11: the mask holds while asleep.
   p_sleep_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(wr_mask));

endmodule

// File: rtl/bsw_data_regs.sv
module bsw_data_regs #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   localparam int LANES = DATA_W / BYTE_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LO = l * BYTE_W;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wdata_q[LO +: BYTE_W] <= '0;
            rdata_q[LO +: BYTE_W] <= '0;
         end else if (run) begin
            wdata_q[LO +: BYTE_W] <= wdata_in[LO +: BYTE_W];
            rdata_q[LO +: BYTE_W] <= mem_rdata[LO +: BYTE_W];
         end
      end
   end

   // R6: the write path captures its input at each active edge.
   p_wdata_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (wdata_q == $past(wdata_in)));

   // R11: both data registers hold while asleep.
   p_sleep_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(wdata_q) && $stable(rdata_q)));

endmodule

// File: rtl/bsw_drive_ctrl.sv
module bsw_drive_ctrl #(
   parameter bit DUAL_BANK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_now,
   input  logic oe_n,
   input  logic wr_busy,
   output logic drive_en
);

   logic sel_q;
   logic bank_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel_q <= 1'b0;
      else if (run) sel_q <= sel_now;
   end

   if (DUAL_BANK) begin : g_dual
      logic sel_d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sel_d <= 1'b0;
         else if (run) sel_d <= sel_q;
      end

      always_comb bank_ok = sel_d;

      // R9: the first cycle after a reselection never drives.
      p_reselect_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (run && sel_now && !sel_q) |=> !drive_en);
   end else begin : g_single
      always_comb bank_ok = 1'b1;
   end

   always_comb drive_en = !oe_n && !wr_busy && sel_q && bank_ok;

   // R12: a deselecting edge turns the drivers off.
   p_deselect_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !sel_now) |=> !drive_en);

endmodule

// File: rtl/bsram_wr_oe_ctl.sv
module bsram_wr_oe_ctl #(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit DUAL_BANK = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     gw_n,
   input  logic                     bwg_n,
   input  logic [DATA_W/BYTE_W-1:0] be_n,
   input  logic                     ads_n,
   input  logic                     ce_n,
   input  logic                     cs_hi,
   input  logic                     cs_lo_n,
   input  logic                     oe_n,
   input  logic [DATA_W-1:0]        wdata_in,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic [DATA_W/BYTE_W-1:0] wr_mask,
   output logic [DATA_W-1:0]        wdata_q,
   output logic [DATA_W-1:0]        rdata_q,
   output logic                     drive_en
);

   localparam int NUM_LANES = DATA_W / BYTE_W;

   if (BYTE_W < 1 || DATA_W < BYTE_W || (DATA_W % BYTE_W) != 0) begin : g_bad_width
      $error("bsram_wr_oe_ctl: DATA_W must be a positive multiple of BYTE_W");
   end

   logic run;
   logic sel_now;
   logic wr_busy;

   always_comb run     = !sleep;
   always_comb sel_now = !ce_n && cs_hi && !cs_lo_n;
   always_comb wr_busy = |wr_mask;

   bsw_write_decode #(.NUM_LANES(NUM_LANES)) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .gw_n    (gw_n),
      .bwg_n   (bwg_n),
      .be_n    (be_n),
      .ads_n   (ads_n),
      .wr_mask (wr_mask)
   );

   bsw_data_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .wdata_in  (wdata_in),
      .mem_rdata (mem_rdata),
      .wdata_q   (wdata_q),
      .rdata_q   (rdata_q)
   );

   bsw_drive_ctrl #(.DUAL_BANK(DUAL_BANK)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sel_now  (sel_now),
      .oe_n     (oe_n),
      .wr_busy  (wr_busy),
      .drive_en (drive_en)
   );

   // R7: a pending write keeps the drivers off.
   p_write_blocks_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask != '0) |-> !drive_en);

   // R8: output enable high keeps the drivers off.
   p_oe_high_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_en);

   // R1: the reset state.
   always_comb begin
      if (!rst_n) begin
         a_reset_state_r1: assert (wr_mask == '0 && !drive_en);
      end
   end

endmodule

// File: tb/bsram_wr_oe_ctl_bench.sv
module bsram_wr_oe_ctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep = 1'b0;
   logic        gw_n = 1'b1;
   logic        bwg_n = 1'b1;
   logic [3:0]  be_n = 4'hF;
   logic        ads_n = 1'b1;
   logic        ce_n = 1'b1;
   logic        cs_hi = 1'b0;
   logic        cs_lo_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [31:0] wdata_in = '0;
   logic [31:0] mem_rdata = '0;

   logic [3:0]  wr_mask, wr_mask_s;
   logic [31:0] wdata_q, rdata_q, wdata_q_s, rdata_q_s;
   logic        drive_en, drive_en_s;

   int checks = 0;
   int fails  = 0;
   int seed   = 1;
   string cur_req = "R1";

   always #2 clk = ~clk;

   bsram_wr_oe_ctl #(.DATA_W(32), .BYTE_W(8), .DUAL_BANK(1'b1)) u_bsram_wr_oe_ctl (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .gw_n(gw_n), .bwg_n(bwg_n),
      .be_n(be_n), .ads_n(ads_n), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .oe_n(oe_n), .wdata_in(wdata_in), .mem_rdata(mem_rdata),
      .wr_mask(wr_mask), .wdata_q(wdata_q), .rdata_q(rdata_q), .drive_en(drive_en));

   bsram_wr_oe_ctl #(.DATA_W(32), .BYTE_W(8), .DUAL_BANK(1'b0)) u_bsram_wr_oe_ctl_sb (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .gw_n(gw_n), .bwg_n(bwg_n),
      .be_n(be_n), .ads_n(ads_n), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .oe_n(oe_n), .wdata_in(wdata_in), .mem_rdata(mem_rdata),
      .wr_mask(wr_mask_s), .wdata_q(wdata_q_s), .rdata_q(rdata_q_s), .drive_en(drive_en_s));

   // Reference model: state as the requirements describe it.
   logic [3:0]  m_mask;
   logic [31:0] m_wd, m_rd;
   logic        m_sel, m_sel_prev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask <= 4'h0; m_wd <= '0; m_rd <= '0; m_sel <= 1'b0; m_sel_prev <= 1'b0;
      end else if (!sleep) begin
         if (!ads_n)      m_mask <= 4'h0;          // R5
         else if (!gw_n)  m_mask <= 4'hF;          // R2
         else if (!bwg_n) m_mask <= ~be_n;         // R3
         else             m_mask <= 4'h0;          // R4
         m_wd <= wdata_in;                         // R6
         m_rd <= mem_rdata;
         m_sel_prev <= m_sel;
         m_sel <= (ce_n == 1'b0) && (cs_hi == 1'b1) && (cs_lo_n == 1'b0);
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic exp_dual, exp_single;
      exp_single = !oe_n && (m_mask == 4'h0) && m_sel;
      exp_dual   = exp_single && m_sel_prev;
      chk(cur_req, "wr_mask", {28'h0, wr_mask}, {28'h0, m_mask});
      chk(cur_req, "wr_mask single", {28'h0, wr_mask_s}, {28'h0, m_mask});
      chk("R6", "wdata_q", wdata_q, m_wd);
      chk("R6", "rdata_q", rdata_q, m_rd);
      chk(cur_req, "drive_en dual", {31'h0, drive_en}, {31'h0, exp_dual});
      chk(cur_req, "drive_en single", {31'h0, drive_en_s}, {31'h0, exp_single});
   endtask

   // Wait for the falling edge, compare, then drive the next inputs.
   task automatic step(input logic g, input logic bg, input logic [3:0] b, input logic a,
                       input logic c, input logic ch, input logic cl, input logic o, input logic s);
      @(negedge clk);
      compare_all();
      gw_n = g; bwg_n = bg; be_n = b; ads_n = a; ce_n = c; cs_hi = ch; cs_lo_n = cl;
      oe_n = o; sleep = s;
      seed = seed * 1103515245 + 12345;
      wdata_in  = seed;
      mem_rdata = seed ^ 32'h5A5A_C3C3;
   endtask

   // Selected, output enabled, no write, awake.
   task automatic idle_sel();
      step(1, 1, 4'hF, 1, 0, 1, 0, 0, 0);
   endtask

   bit done = 0;
   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset holds everything at zero even with active inputs.
      cur_req = "R1";
      gw_n = 0; ce_n = 0; cs_hi = 1; cs_lo_n = 0; oe_n = 0; wdata_in = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      chk("R1", "reset wr_mask", {28'h0, wr_mask}, 32'h0);
      chk("R1", "reset wdata_q", wdata_q, 32'h0);
      chk("R1", "reset drive_en", {31'h0, drive_en}, 32'h0);
      chk("R1", "reset drive_en single", {31'h0, drive_en_s}, 32'h0);
      gw_n = 1; ce_n = 1; cs_hi = 0; cs_lo_n = 1; oe_n = 1;
      @(negedge clk);
      rst_n = 1;

      // R2: a global write overrides gate and byte enables.
      cur_req = "R2";
      for (int k = 0; k < 8; k++) step(0, k[0], {k[2:1], k[1:0]}, 1, 0, 1, 0, 0, 0);
      @(negedge clk);
      chk("R2", "global write mask", {28'h0, wr_mask}, 32'hF);
      chk("R7", "drive off during write", {31'h0, drive_en_s}, 32'h0);

      // R3: every byte-enable pattern through the open gate.
      cur_req = "R3";
      for (int k = 0; k < 16; k++) step(1, 0, k[3:0], 1, 0, 1, 0, 0, 0);
      step(1, 0, 4'b1110, 1, 0, 1, 0, 0, 0);
      @(negedge clk);
      chk("R3", "lane 0 only (bits 7:0)", {28'h0, wr_mask}, 32'h1);
      step(1, 0, 4'b0111, 1, 0, 1, 0, 0, 0);
      @(negedge clk);
      chk("R3", "lane 3 only (bits 31:24)", {28'h0, wr_mask}, 32'h8);

      // R4: a closed gate blocks the byte enables.
      cur_req = "R4";
      for (int k = 0; k < 16; k++) step(1, 1, k[3:0], 1, 0, 1, 0, 0, 0);

      // R5: the strobe vetoes both write paths.
      cur_req = "R5";
      step(0, 0, 4'h0, 0, 0, 1, 0, 0, 0);
      @(negedge clk);
      chk("R5", "strobe veto", {28'h0, wr_mask}, 32'h0);
      for (int k = 0; k < 8; k++) step(k[0], k[1], 4'h0, 0, 0, 1, 0, 0, 0);

      // R8: the output enable acts within the cycle.
      cur_req = "R8";
      repeat (3) idle_sel();
      step(1, 1, 4'hF, 1, 0, 1, 0, 1, 0);
      #0;
      chk("R8", "oe high single", {31'h0, drive_en_s}, 32'h0);
      chk("R8", "oe high dual", {31'h0, drive_en}, 32'h0);
      repeat (4) step(1, 1, 4'hF, 1, 0, 1, 0, 1, 0);

      // R9 and R10: deselect, then reselect.
      cur_req = "R9";
      repeat (3) step(1, 1, 4'hF, 1, 1, 1, 0, 0, 0);
      idle_sel();
      @(negedge clk);
      chk("R9", "dual gap after reselect", {31'h0, drive_en}, 32'h0);
      chk("R10", "single no gap", {31'h0, drive_en_s}, 32'h1);
      idle_sel();
      @(negedge clk);
      chk("R9", "dual on one cycle later", {31'h0, drive_en}, 32'h1);

      // R12: each select pin alone deselects.
      cur_req = "R12";
      for (int k = 0; k < 8; k++) begin
         step(1, 1, 4'hF, 1, k[0], !k[1], k[2], 0, 0);
         idle_sel();
         idle_sel();
      end

      // R11: sleep freezes all state while inputs move.
      cur_req = "R11";
      step(0, 1, 4'hF, 1, 0, 1, 0, 0, 0);
      step(1, 0, 4'h5, 1, 1, 0, 1, 0, 1);
      repeat (4) step(1, 0, 4'h0, 1, 1, 0, 1, 0, 1);
      @(negedge clk);
      chk("R11", "mask held in sleep", {28'h0, wr_mask}, 32'hF);
      step(1, 1, 4'hF, 1, 0, 1, 0, 0, 0);

      // Mixed stretch: everything at once.
      cur_req = "R12";
      for (int k = 0; k < 600; k++) begin
         int r;
         seed = seed * 1103515245 + 12345;
         r = seed >>> 7;
         step(r[0] | r[1], r[2], r[6:3], r[7] | r[8] | r[9], r[10] & r[11], 1, 0,
              r[12] & r[13], r[14] & r[15] & r[16]);
      end

      @(negedge clk);
      compare_all();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule